// File: doc/BRIEF.md
# Modem Line Status and Control Unit

This block sits beside a serial port and handles its six modem handshake lines. Four of them arrive from the far end: carrier detect, ring indicator, data-set-ready and clear-to-send. Each passes through a two-flop synchroniser, and its settled level is shown in a status register. The block also keeps one sticky change flag per input. The carrier, data-set-ready and clear-to-send flags set on any edge. The ring flag sets only when the ring signal falls, which marks the end of a ring.

Whenever a change flag goes from clear to set, the block sends a one-cycle change event to the interrupt logic. Software clears a flag by writing a one to its bit in the status register. The other two lines, data-terminal-ready and request-to-send, are outputs driven from a control register. That register also stores an automatic flow-control enable bit, and the status register stores a flow-control mode bit. Neither stored bit affects the transmitter from inside this block.

Register access is a single-cycle write strobe plus a combinational read port. The two register offsets are parameters.

Top module: `modem_line_unit`

## Requirements
- R1: After reset, every change flag reads 0, the control register reads 0, the data-terminal-ready and request-to-send outputs are low, and the change event is low.
- R2: Status register bits 7, 6, 5 and 4 show the synchronised levels of carrier detect, ring, data-set-ready and clear-to-send. A pin change becomes visible there two clocks after it is sampled.
- R3: The change flags for carrier detect (status bit 3), data-set-ready (bit 1) and clear-to-send (bit 0) set on both rising and falling edges of their pins. A flag sets on the third clock after the pin changes.
- R4: The ring flag (status bit 2) sets only on a falling edge of the ring pin. A rising edge leaves the flag unchanged.
- R5: A change flag stays set until software writes a one to its bit in the status register. Writing a zero to that bit leaves the flag set.
- R6: If a flag is set and cleared on the same clock, the set wins and the flag reads 1 afterwards.
- R7: The change event is high for exactly the one cycle after a clock edge at which at least one flag went from 0 to 1. A new edge on a pin whose flag is already set does not raise the event.
- R8: The control register is at offset 0x24. Bit 0 drives data-terminal-ready and bit 1 drives request-to-send, and both outputs follow a write on the next clock. Bit 5 is a stored flow-control enable. All other bits read 0.
- R9: Status register bit 8 (offset 0x28) is a read/write flow-control mode bit. Writes to the level bits 7 to 4 have no effect.
- R10: A read of any address other than the two registers returns 0, and a write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| carrier_in | input | 1 | Carrier detect pin, asynchronous |
| ring_in | input | 1 | Ring indicator pin, asynchronous |
| dsr_in | input | 1 | Data-set-ready pin, asynchronous |
| cts_in | input | 1 | Clear-to-send pin, asynchronous |
| dtr_out | output | 1 | Data-terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| chg_evt | output | 1 | One-cycle modem change event |

## Verification
Random four-bit pin patterns are applied one step at a time, so that single, multiple and no-change steps all occur, and each is followed by a random clear mask. Together these separate either-edge detection from falling-edge detection and show that flags persist across unrelated clears. Directed cases apply a rising ring edge alone, a second edge on a pin whose flag is already set (which must raise no event), and a clear that lands on the same clock as a new set. These three cases catch a wrong ring polarity, an event derived from levels instead of from the flag going 0 to 1, and the wrong priority between set and clear.

// File: rtl/modem_line_pkg.sv
package modem_line_pkg;
  localparam int LINE_W      = 4;
  // index of each line inside the 4-bit vectors (matches status bit order)
  localparam int IDX_CTS     = 0;
  localparam int IDX_DSR     = 1;
  localparam int IDX_RING    = 2;
  localparam int IDX_CARRIER = 3;
  localparam int LVL_LSB     = 4;
  localparam int FCMODE_BIT  = 8;
  localparam int CTL_DTR     = 0;
  localparam int CTL_RTS     = 1;
  localparam int CTL_AUTOFC  = 5;

  // set requests from old and new synchronised levels
  function automatic logic [LINE_W-1:0] edge_req(input logic [LINE_W-1:0] prev,
                                                 input logic [LINE_W-1:0] cur);
    logic [LINE_W-1:0] r;
    r = prev ^ cur;
    r[IDX_RING] = prev[IDX_RING] & ~cur[IDX_RING];
    return r;
  endfunction
endpackage

// File: rtl/modem_line_sync.sv
module modem_line_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/modem_line_delta.sv
module modem_line_delta
  import modem_line_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] lvl,
  input  logic [LINE_W-1:0] clr_vec,
  output logic [LINE_W-1:0] set_req,
  output logic [LINE_W-1:0] dflag,
  output logic              evt
);
  logic [LINE_W-1:0] prev_q;
  logic [LINE_W-1:0] dflag_nxt;

  assign set_req   = edge_req(prev_q, lvl);
  assign dflag_nxt = (dflag & ~clr_vec) | set_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      dflag  <= '0;
      evt    <= 1'b0;
    end else begin
      prev_q <= lvl;
      dflag  <= dflag_nxt;
      evt    <= |(set_req & ~dflag);
    end
  end
endmodule

// File: rtl/modem_line_regs.sv
module modem_line_regs
  import modem_line_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dtr_q,
  output logic              rts_q,
  output logic              autofc_q,
  output logic              fcmode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtr_q    <= 1'b0;
      rts_q    <= 1'b0;
      autofc_q <= 1'b0;
      fcmode_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        dtr_q    <= wr_data[CTL_DTR];
        rts_q    <= wr_data[CTL_RTS];
        autofc_q <= wr_data[CTL_AUTOFC];
      end
      if (stat_we) fcmode_q <= wr_data[FCMODE_BIT];
    end
  end
endmodule

// File: rtl/modem_line_unit.sv
module modem_line_unit
  import modem_line_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 32,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h24,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              carrier_in,
  input  logic              ring_in,
  input  logic              dsr_in,
  input  logic              cts_in,
  output logic              dtr_out,
  output logic              rts_out,
  output logic              chg_evt
);
  logic [LINE_W-1:0] pins_raw;
  logic [LINE_W-1:0] lvl_sync;
  logic [LINE_W-1:0] set_req;
  logic [LINE_W-1:0] dflag;
  logic [LINE_W-1:0] clr_vec;
  logic              ctl_we, stat_we;
  logic              autofc_q, fcmode_q;

  assign pins_raw = {carrier_in, ring_in, dsr_in, cts_in};
  assign ctl_we   = wr_en && (wr_addr == CTRL_OFS);
  assign stat_we  = wr_en && (wr_addr == STAT_OFS);
  assign clr_vec  = stat_we ? wr_data[LINE_W-1:0] : '0;

  modem_line_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pins_raw), .sync_out(lvl_sync)
  );

  modem_line_delta u_delta (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .clr_vec(clr_vec),
    .set_req(set_req), .dflag(dflag), .evt(chg_evt)
  );

  modem_line_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .stat_we(stat_we),
    .wr_data(wr_data), .dtr_q(dtr_out), .rts_q(rts_out),
    .autofc_q(autofc_q), .fcmode_q(fcmode_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_OFS) begin
      rd_data[CTL_DTR]    = dtr_out;
      rd_data[CTL_RTS]    = rts_out;
      rd_data[CTL_AUTOFC] = autofc_q;
    end else if (rd_addr == STAT_OFS) begin
      rd_data[LINE_W-1:0]                 = dflag;
      rd_data[LVL_LSB +: LINE_W]          = lvl_sync;
      rd_data[FCMODE_BIT]                 = fcmode_q;
    end
  end
endmodule

// File: rtl/modem_line_unit_chk.sv
module modem_line_unit_chk
  import modem_line_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic [DATA_W-1:0] wr_data,
  input logic [LINE_W-1:0] lvl_sync,
  input logic [LINE_W-1:0] set_req,
  input logic [LINE_W-1:0] dflag,
  input logic [LINE_W-1:0] clr_vec,
  input logic              chg_evt,
  input logic              dtr_out,
  input logic              rts_out
);
  p_rst_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (dflag == '0 && !dtr_out && !rts_out && !chg_evt));

  p_ring_fall_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dflag[IDX_RING]) |-> !$past(lvl_sync[IDX_RING]));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(dflag) & ~$past(clr_vec) & ~dflag) == '0));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req != '0) |=> ((dflag & $past(set_req)) == $past(set_req)));

  p_evt_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> ((dflag & ~$past(dflag)) != '0));

  p_evt_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_req & ~dflag) != '0) |=> chg_evt);

  p_ctl_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (dtr_out == $past(wr_data[CTL_DTR]) && rts_out == $past(wr_data[CTL_RTS])));
endmodule

bind modem_line_unit modem_line_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wr_data(wr_data),
  .lvl_sync(lvl_sync), .set_req(set_req), .dflag(dflag), .clr_vec(clr_vec),
  .chg_evt(chg_evt), .dtr_out(dtr_out), .rts_out(rts_out)
);

// File: tb/sim_modem_line_unit.sv
`timescale 1ns/1ps
module sim_modem_line_unit;
  localparam logic [7:0] A_CTL  = 8'h24;
  localparam logic [7:0] A_STAT = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  pins = '0;   // {carrier, ring, dsr, cts}
  logic        dtr_out, rts_out, chg_evt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  modem_line_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .carrier_in(pins[3]), .ring_in(pins[2]), .dsr_in(pins[1]), .cts_in(pins[0]),
    .dtr_out(dtr_out), .rts_out(rts_out), .chg_evt(chg_evt)
  );

  // expected set mask: either edge on carrier/dsr/cts, falling edge on ring
  function automatic logic [3:0] want_set(input logic [3:0] was, input logic [3:0] now);
    logic [3:0] m;
    m[3] = was[3] != now[3];
    m[2] = was[2] && !now[2];
    m[1] = was[1] != now[1];
    m[0] = was[0] != now[0];
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  exp_fl, sm, was, nxt, mask;
    void'($urandom(32'd1234));
    step(4);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    rd(A_STAT, d); check("R1 status", d, 32'h0);
    rd(A_CTL, d);  check("R1 control", d, 32'h0);
    check("R1 outputs", {30'b0, dtr_out, rts_out}, 32'h0);
    check("R1 event", {31'b0, chg_evt}, 32'h0);

    // R8 control register
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, d); check("R8 readback", d, 32'h23);
    check("R8 pins all", {30'b0, dtr_out, rts_out}, 32'h3);
    wr(A_CTL, 32'h2);
    check("R8 pins rts only", {30'b0, dtr_out, rts_out}, 32'h1);

    // R9 mode bit stored, level bits not writable
    wr(A_STAT, 32'h1F0);
    rd(A_STAT, d); check("R9 mode set", d & 32'h1FF, 32'h100);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R9 mode clear", d, 32'h0);

    // R10 unmapped address
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, d); check("R10 unmapped read", d, 32'h0);
    rd(A_CTL, d); check("R10 control intact", d, 32'h2);

    // R2/R4 ring rising edge: level shows, flag stays clear, no event
    pins = 4'b0100;
    step(2);
    rd(A_STAT, d); check("R2 level after two clocks", d & 32'hF0, 32'h40);
    step(1);
    rd(A_STAT, d); check("R4 rising ring no flag", d, 32'h40);
    check("R4 rising ring no event", {31'b0, chg_evt}, 32'h0);
    // R4/R7 falling edge sets ring flag and pulses event
    pins = 4'b0000;
    step(3);
    rd(A_STAT, d); check("R4 falling ring flag", d, 32'h04);
    check("R7 event pulse", {31'b0, chg_evt}, 32'h1);
    step(1);
    check("R7 event one cycle", {31'b0, chg_evt}, 32'h0);

    // R5 sticky: writing zero keeps it, writing one clears it
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R5 zero write keeps", d, 32'h04);
    wr(A_STAT, 32'h4);
    rd(A_STAT, d); check("R5 one write clears", d, 32'h0);

    // R3/R7 carrier rises, then toggles again with flag set: no new event
    pins = 4'b1000;
    step(3);
    rd(A_STAT, d); check("R3 carrier rise flag", d, 32'h88);
    check("R7 carrier event", {31'b0, chg_evt}, 32'h1);
    pins = 4'b0000;
    step(3);
    rd(A_STAT, d); check("R3 carrier fall flag kept", d, 32'h08);
    check("R7 no event when already set", {31'b0, chg_evt}, 32'h0);

    // R6 clear landing on the same clock as a new set
    pins = 4'b0001;
    step(2);
    wr_en = 1'b1; wr_addr = A_STAT; wr_data = 32'h9;
    step(1);
    wr_en = 1'b0; wr_data = '0;
    rd(A_STAT, d); check("R6 set beats clear", d, 32'h11);
    wr(A_STAT, 32'hF);

    // random pin steps with random clears
    exp_fl = 4'h0;
    was = pins;
    for (int it = 0; it < 300; it++) begin
      nxt = 4'($urandom);
      pins = nxt;
      sm = want_set(was, nxt);
      step(3);
      rd(A_STAT, d);
      check("R3 R4 random status", d, {23'b0, 1'b0, nxt, exp_fl | sm});
      check("R7 random event", {31'b0, chg_evt}, {31'b0, |(sm & ~exp_fl)});
      exp_fl = exp_fl | sm;
      mask = 4'($urandom);
      wr(A_STAT, {28'b0, mask});
      exp_fl = exp_fl & ~mask;
      rd(A_STAT, d);
      check("R5 random clear", d & 32'hF, {28'b0, exp_fl});
      was = nxt;
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule